// File: doc/BRIEF.md
# Configuration Transaction Controller

This block is a command-style configuration port built from three software-visible registers: a data word, a command word and a two-bit result word. Software first puts an operand into the data word, then writes the command word. That single write holds a start flag, a direction flag and fields that name an interface unit, an operation, a board site, a stack position and a device number. When the start flag is set, the block decodes the request against a small internal table in the same cycle. The table holds writable oscillator frequency entries for the main board and the daughter board, plus fixed supply voltage readings.

A supported write takes its value from the data word. A supported read loads its result into the data word. Shutdown and reboot commands each raise a one-cycle request pulse on their own output. Every started command leaves "complete" in the result word, and unsupported requests add "error". The daughter-board oscillator count, its reset frequencies and the daughter-board voltage readings are parameters.

Top module: `cfgx_port`

## Requirements
- R1: After reset the data, command and result words read 0. The main-board oscillators hold 50000000, 23750000, 24000000, 24000000, 24000000 and 24000000 for devices 0 to 5. Daughter-board oscillator d holds bits [32d+31:32d] of the DB_OSC_INIT parameter.
- R2: A write to the command word stores bits [30:20] and [17:0] of the written value. Bits 31, 19 and 18 always read back as 0. A command write with bit 31 clear changes nothing else, and the result word keeps its value.
- R3: A command write with bit 31 set executes the request in that cycle. The result word then reads 1 (complete) on success and 3 (complete plus error) on failure.
- R4: A request fails unless unit select [29:26] is 0, position [15:12] is 0, and site [17:16] is 0 (main board) or 1 (daughter board).
- R5: Function [25:20] = 1 addresses an oscillator. Site 0 covers devices 0 to 5. Site 1 covers devices 0 to NUM_DB_OSC-1. Bit 30 = 1 writes the data word into the entry, and bit 30 = 0 loads the entry into the data word. A device beyond the range fails.
- R6: Function 2 is a voltage read. Main-board device 0 returns 3300000, and daughter-board device d returns bits [32d+31:32d] of DB_VOLT_VAL for d below NUM_DB_VOLT. Any other device fails, a write (bit 30 = 1) fails, and no oscillator entry changes.
- R7: Functions 7 (video source select) and 11 (display mode) succeed only as writes to main-board device 0, and they change no stored value. Any other form of these functions fails.
- R8: Functions 8 (shutdown) and 9 (reboot) succeed only as writes to main-board device 0. On success the block drives shutdownReq or rebootReq high for exactly the one cycle after the command edge. A failed request produces no pulse.
- R9: Function codes other than 1, 2, 7, 8, 9 and 11 fail. A failed request leaves the data word unchanged.
- R10: A write to the result word stores bits [1:0] of the written value.
- R11: regSel selects the register: 0 is the data word, 1 the command word and 2 the result word. Selector 3 reads 0, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| regSel | input | 2 | Register selector for read and write |
| wrEn | input | 1 | Write strobe for the selected register |
| wrData | input | 32 | Write value |
| rdData | output | 32 | Selected register value, combinational |
| shutdownReq | output | 1 | One-cycle shutdown request |
| rebootReq | output | 1 | One-cycle reboot request |

## Verification
Two functions share one edge: a started command stores the masked command word, and at that same edge it commits its result, whether a loaded data word, an updated oscillator entry or a request pulse, together with the result word. The bench issues started commands back to back, each followed at once by reads of all three words and a look at both request outputs in the following cycle. Every value is judged against a bench model that applies the field decode from the requirements. Random commands mix legal and illegal fields, and directed cases cover the range edges of each device table.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
  localparam int IDX_W = 8;
  localparam int MAIN_OSC = 6;

  localparam logic [1:0] SEL_DATA = 2'd0;
  localparam logic [1:0] SEL_CMD  = 2'd1;
  localparam logic [1:0] SEL_STAT = 2'd2;

  localparam logic [5:0] FN_OSC   = 6'd1;
  localparam logic [5:0] FN_VOLT  = 6'd2;
  localparam logic [5:0] FN_VIDEO = 6'd7;
  localparam logic [5:0] FN_OFF   = 6'd8;
  localparam logic [5:0] FN_BOOT  = 6'd9;
  localparam logic [5:0] FN_DISP  = 6'd11;

  localparam logic [1:0] SITE_MAIN = 2'd0;
  localparam logic [1:0] SITE_DGTR = 2'd1;

  localparam logic [31:0] CMD_KEEP = 32'h7FF3_FFFF;
  localparam logic [31:0] MAIN_VOLT = 32'd3300000;

  typedef struct packed {
    logic             exec;
    logic             fail;
    logic             oscWr;
    logic             oscRd;
    logic             voltRd;
    logic [IDX_W-1:0] idx;
    logic             offReq;
    logic             bootReq;
  } strobe_t;
endpackage

// File: rtl/cfgx_ctrl.sv
module cfgx_ctrl
  import cfgx_pkg::*;
#(
  parameter int NUM_DB_OSC  = 2,
  parameter int NUM_DB_VOLT = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdWr,
  input  logic [31:0] wrData,
  output strobe_t     stb,
  output logic        shutdownReq,
  output logic        rebootReq
);
  logic        startHit, dirWr, addrOk, onMain, onDgtr, ok;
  logic [3:0]  unitSel, posSel;
  logic [5:0]  fnCode;
  logic [1:0]  siteSel;
  logic [11:0] devNum;
  logic [31:0] devWide;

  assign startHit = cmdWr && wrData[31];
  assign dirWr    = wrData[30];
  assign unitSel  = wrData[29:26];
  assign fnCode   = wrData[25:20];
  assign siteSel  = wrData[17:16];
  assign posSel   = wrData[15:12];
  assign devNum   = wrData[11:0];
  assign devWide  = {20'd0, devNum};
  assign onMain   = siteSel == SITE_MAIN;
  assign onDgtr   = siteSel == SITE_DGTR;
  assign addrOk   = (unitSel == 4'd0) && (posSel == 4'd0) && (onMain || onDgtr);

  always_comb begin
    stb = '0;
    ok  = 1'b0;
    if (addrOk) begin
      unique case (fnCode)
        FN_OSC: begin
          if (onMain && devWide < 32'(MAIN_OSC)) begin
            ok = 1'b1;
            stb.idx = IDX_W'(devNum);
          end else if (onDgtr && devWide < 32'(NUM_DB_OSC)) begin
            ok = 1'b1;
            stb.idx = IDX_W'(devNum) + IDX_W'(MAIN_OSC);
          end
          stb.oscWr = ok && dirWr;
          stb.oscRd = ok && !dirWr;
        end
        FN_VOLT: begin
          if (!dirWr && onMain && devNum == 12'd0) begin
            ok = 1'b1;
            stb.idx = '0;
          end else if (!dirWr && onDgtr && devWide < 32'(NUM_DB_VOLT)) begin
            ok = 1'b1;
            stb.idx = IDX_W'(devNum) + IDX_W'(1);
          end
          stb.voltRd = ok;
        end
        FN_VIDEO, FN_DISP, FN_OFF, FN_BOOT: begin
          ok = dirWr && onMain && devNum == 12'd0;
          stb.offReq  = ok && fnCode == FN_OFF;
          stb.bootReq = ok && fnCode == FN_BOOT;
        end
        default: ok = 1'b0;
      endcase
    end
    if (!startHit) begin
      stb = '0;
    end else begin
      stb.exec = 1'b1;
      stb.fail = !ok;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shutdownReq <= 1'b0;
      rebootReq   <= 1'b0;
    end else begin
      shutdownReq <= stb.offReq;
      rebootReq   <= stb.bootReq;
    end
  end

  p_req_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({shutdownReq, rebootReq}));
  p_off_src_r8: assert property (@(posedge clk) disable iff (!rstN)
    shutdownReq |-> $past(cmdWr && wrData[31] && wrData[30] && wrData[25:20] == FN_OFF));
endmodule

// File: rtl/cfgx_dp.sv
module cfgx_dp
  import cfgx_pkg::*;
#(
  parameter int NUM_DB_OSC  = 2,
  parameter int NUM_DB_VOLT = 2,
  parameter logic [NUM_DB_OSC*32-1:0]  DB_OSC_INIT = '0,
  parameter logic [NUM_DB_VOLT*32-1:0] DB_VOLT_VAL = '0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  regSel,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  input  strobe_t     stb,
  output logic [31:0] rdData
);
  localparam int NUM_OSC = MAIN_OSC + NUM_DB_OSC;

  logic [31:0] dataReg, cmdReg;
  logic [1:0]  statReg;
  logic [NUM_OSC-1:0][31:0] oscTbl;
  logic [31:0] oscVal, voltVal;

  function automatic logic [31:0] oscReset(input int i);
    if (i == 0) return 32'd50000000;
    if (i == 1) return 32'd23750000;
    if (i < MAIN_OSC) return 32'd24000000;
    return DB_OSC_INIT[(i-MAIN_OSC)*32 +: 32];
  endfunction

  for (genvar g = 0; g < NUM_OSC; g++) begin : g_osc
    localparam logic [31:0] INIT = oscReset(g);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) oscTbl[g] <= INIT;
      else if (stb.oscWr && stb.idx == IDX_W'(g)) oscTbl[g] <= dataReg;
    end
  end

  always_comb begin
    oscVal = '0;
    for (int i = 0; i < NUM_OSC; i++)
      if (stb.idx == IDX_W'(i)) oscVal = oscTbl[i];
    voltVal = MAIN_VOLT;
    for (int v = 0; v < NUM_DB_VOLT; v++)
      if (stb.idx == IDX_W'(v + 1)) voltVal = DB_VOLT_VAL[v*32 +: 32];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg <= '0;
      cmdReg  <= '0;
      statReg <= '0;
    end else begin
      if (wrEn && regSel == SEL_DATA) dataReg <= wrData;
      if (wrEn && regSel == SEL_CMD)  cmdReg  <= wrData & CMD_KEEP;
      if (wrEn && regSel == SEL_STAT) statReg <= wrData[1:0];
      if (stb.oscRd)  dataReg <= oscVal;
      if (stb.voltRd) dataReg <= voltVal;
      if (stb.exec)   statReg <= {stb.fail, 1'b1};
    end
  end

  always_comb begin
    unique case (regSel)
      SEL_DATA: rdData = dataReg;
      SEL_CMD:  rdData = cmdReg;
      SEL_STAT: rdData = {30'd0, statReg};
      default:  rdData = '0;
    endcase
  end

  p_exec_done_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regSel == SEL_CMD && wrData[31]) |=> statReg[0]);
  p_unit_fail_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regSel == SEL_CMD && wrData[31] && wrData[29:26] != 4'd0) |=> statReg == 2'b11);
  p_fail_keep_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.exec && stb.fail) |=> $stable(dataReg));
  p_volt_ro_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regSel == SEL_CMD && wrData[31] && wrData[25:20] == FN_VOLT) |=> $stable(oscTbl));
endmodule

// File: rtl/cfgx_port.sv
module cfgx_port
  import cfgx_pkg::*;
#(
  parameter int NUM_DB_OSC  = 2,
  parameter int NUM_DB_VOLT = 2,
  parameter logic [NUM_DB_OSC*32-1:0]  DB_OSC_INIT = {32'd45000000, 32'd60000000},
  parameter logic [NUM_DB_VOLT*32-1:0] DB_VOLT_VAL = {32'd1800000, 32'd1000000}
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  regSel,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        shutdownReq,
  output logic        rebootReq
);
  strobe_t stb;
  logic cmdWr;
  assign cmdWr = wrEn && regSel == SEL_CMD;

  cfgx_ctrl #(.NUM_DB_OSC(NUM_DB_OSC), .NUM_DB_VOLT(NUM_DB_VOLT)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .wrData(wrData), .stb(stb),
    .shutdownReq(shutdownReq), .rebootReq(rebootReq));

  cfgx_dp #(.NUM_DB_OSC(NUM_DB_OSC), .NUM_DB_VOLT(NUM_DB_VOLT),
            .DB_OSC_INIT(DB_OSC_INIT), .DB_VOLT_VAL(DB_VOLT_VAL)) u_dp (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .wrData(wrData),
    .stb(stb), .rdData(rdData));
endmodule

// File: tb/tb_cfgx_port.sv
`timescale 1ns/1ps
module tb_cfgx_port;
  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0;
  logic [1:0] regSel = 2'd0;
  logic [31:0] wrData = '0, rdData;
  logic shutdownReq, rebootReq;
  int total = 0, bad = 0;

  cfgx_port dut (.clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .shutdownReq(shutdownReq), .rebootReq(rebootReq));

  always #2.5 clk = ~clk;

  logic [31:0] mOsc [6];
  logic [31:0] dOsc [2];
  logic [31:0] dVolt [2];
  logic [31:0] expData, expCmd;
  logic [1:0]  expStat;
  logic expOff, expBoot;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] v);
    @(negedge clk); regSel = s; wrData = v; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    regSel = s; #1; v = rdData;
  endtask

  task automatic predict(input logic [31:0] w);
    logic ok, dw, m, d;
    logic [5:0] fn; logic [11:0] dev;
    expCmd = w & 32'h7FF3_FFFF; expOff = 0; expBoot = 0;
    if (!w[31]) return;
    ok = 0; dw = w[30]; fn = w[25:20]; dev = w[11:0];
    m = w[17:16] == 2'd0; d = w[17:16] == 2'd1;
    if (w[29:26] == 0 && w[15:12] == 0 && (m || d)) begin
      case (fn)
        6'd1: if (m && dev < 6) begin
                ok = 1; if (dw) mOsc[dev] = expData; else expData = mOsc[dev];
              end else if (d && dev < 2) begin
                ok = 1; if (dw) dOsc[dev] = expData; else expData = dOsc[dev];
              end
        6'd2: if (!dw && m && dev == 0) begin ok = 1; expData = 32'd3300000; end
              else if (!dw && d && dev < 2) begin ok = 1; expData = dVolt[dev]; end
        6'd7, 6'd11, 6'd8, 6'd9: begin
              ok = dw && m && dev == 0;
              expOff = ok && fn == 6'd8; expBoot = ok && fn == 6'd9;
            end
        default: ok = 0;
      endcase
    end
    expStat = ok ? 2'd1 : 2'd3;
  endtask

  task automatic cmd(input string req, input logic [31:0] w);
    logic [31:0] v;
    predict(w);
    wr(2'd1, w);
    chk({req, " shutdown pulse"}, {31'd0, shutdownReq}, {31'd0, expOff});
    chk({req, " reboot pulse"}, {31'd0, rebootReq}, {31'd0, expBoot});
    @(negedge clk);
    chk({req, " R8 pulse ends"}, {30'd0, shutdownReq, rebootReq}, 32'd0);
    rd(2'd1, v); chk({req, " R2 cmd"}, v, expCmd);
    rd(2'd2, v); chk({req, " R3 status"}, v, {30'd0, expStat});
    rd(2'd0, v); chk({req, " data"}, v, expData);
  endtask

  function automatic logic [31:0] mk(input logic st, input logic dw, input logic [3:0] u,
      input logic [5:0] fn, input logic [1:0] site, input logic [3:0] pos, input logic [11:0] dev);
    return {st, dw, u, fn, 2'b00, site, pos, dev};
  endfunction

  task automatic setData(input logic [31:0] v);
    wr(2'd0, v); expData = v;
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h1234));
    mOsc = '{32'd50000000, 32'd23750000, 32'd24000000, 32'd24000000, 32'd24000000, 32'd24000000};
    dOsc = '{32'd60000000, 32'd45000000};
    dVolt = '{32'd1000000, 32'd1800000};
    expData = 0; expCmd = 0; expStat = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    rd(2'd0, v); chk("R1 data reset", v, 0);
    rd(2'd1, v); chk("R1 cmd reset", v, 0);
    rd(2'd2, v); chk("R1 status reset", v, 0);
    for (int i = 0; i < 6; i++) cmd("R1 R5 main osc reset", mk(1,0,0,6'd1,0,0,12'(i)));
    for (int i = 0; i < 2; i++) cmd("R1 R5 dgtr osc reset", mk(1,0,0,6'd1,1,0,12'(i)));
    // R2: no start, reserved bits set, status keeps prior 1
    cmd("R2 no start", 32'h7FFF_FFFF);
    // R10 status write keeps low bits
    wr(2'd2, 32'hFFFF_FFFE); rd(2'd2, v); chk("R10 status write", v, 2);
    wr(2'd2, 32'h0000_0001); rd(2'd2, v); chk("R10 status write", v, 1);
    // R11 selector 3
    setData(32'hCAFE_0001);
    wr(2'd3, 32'hFFFF_FFFF); rd(2'd3, v); chk("R11 sel3 reads 0", v, 0);
    rd(2'd0, v); chk("R11 sel3 write ignored", v, 32'hCAFE_0001);
    // R5 write then read, range edges
    setData(32'd12345678); cmd("R5 osc write main5", mk(1,1,0,6'd1,0,0,12'd5));
    setData(0); cmd("R5 osc read main5", mk(1,0,0,6'd1,0,0,12'd5));
    cmd("R5 main dev6 fails", mk(1,0,0,6'd1,0,0,12'd6));
    setData(32'd777); cmd("R5 osc write dgtr1", mk(1,1,0,6'd1,1,0,12'd1));
    cmd("R5 dgtr dev2 fails", mk(1,1,0,6'd1,1,0,12'd2));
    cmd("R5 osc read dgtr1", mk(1,0,0,6'd1,1,0,12'd1));
    // R6
    cmd("R6 main volt", mk(1,0,0,6'd2,0,0,12'd0));
    cmd("R6 dgtr volt1", mk(1,0,0,6'd2,1,0,12'd1));
    cmd("R6 volt write fails", mk(1,1,0,6'd2,0,0,12'd0));
    cmd("R6 main volt dev1 fails", mk(1,0,0,6'd2,0,0,12'd1));
    // R4
    cmd("R4 unit nonzero", mk(1,0,4'd1,6'd1,0,0,12'd0));
    cmd("R4 position nonzero", mk(1,0,0,6'd1,0,4'd2,12'd0));
    cmd("R4 site 2", mk(1,0,0,6'd2,2,0,12'd0));
    // R7 R8 R9
    cmd("R7 video ok", mk(1,1,0,6'd7,0,0,12'd0));
    cmd("R7 display site1 fails", mk(1,1,0,6'd11,1,0,12'd0));
    cmd("R7 video read fails", mk(1,0,0,6'd7,0,0,12'd0));
    cmd("R8 shutdown", mk(1,1,0,6'd8,0,0,12'd0));
    cmd("R8 reboot", mk(1,1,0,6'd9,0,0,12'd0));
    cmd("R8 reboot read fails", mk(1,0,0,6'd9,0,0,12'd0));
    cmd("R8 shutdown dev1 fails", mk(1,1,0,6'd8,0,0,12'd1));
    cmd("R9 unknown fn", mk(1,0,0,6'd3,0,0,12'd0));
    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [5:0] fns [7] = '{6'd1, 6'd2, 6'd7, 6'd8, 6'd9, 6'd11, 6'd0};
      logic [5:0] fn; logic [31:0] w;
      fn = fns[$urandom % 7];
      if (fn == 0) fn = 6'($urandom);
      if ($urandom % 3 == 0) setData($urandom);
      w = mk($urandom % 8 != 0, 1'($urandom),
             ($urandom % 8 == 0) ? 4'($urandom) : 4'd0, fn,
             ($urandom % 6 == 0) ? 2'($urandom) : 2'($urandom % 2),
             ($urandom % 8 == 0) ? 4'($urandom) : 4'd0,
             12'($urandom % 9));
      w[19:18] = 2'($urandom);
      cmd("R3 R5 R9 random", w);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule